// File: doc/BRIEF.md
# Quad-I/O Lock Register Target

This block is a serial-flash-style SPI target that serves only the lock-register path. Every phase of a command (opcode, address and data) moves one nibble per serial clock over a four-bit data bus. The block stores one lock byte for each sector in a small register array. Software reads an entry with the read-lock command and changes it with the write-lock command. A write takes effect only after a write-enable command has armed the target.

The serial lines are oversampled by the block's own clock. The block detects serial clock and chip-select edges after a short synchronizer. A transaction that is cut short or run long by chip select is dropped, and the target then waits for a fresh opcode. The address is three bytes long by default. Two further commands switch the address to four bytes and back.

Top module: `qlk_lock_target`

## Requirements
- R1: Each byte is sent high nibble first. Within a nibble, DQ3 carries the most significant bit. The opcodes are 0x06 (write enable), 0xE8 (read lock), 0xE5 (write lock), 0xB7 (four-byte address on) and 0xE9 (four-byte address off).
- R2: Out of reset, the address phase is 24 bits long and takes six serial clocks.
- R3: After 0xB7 the address phase is 32 bits (eight clocks). After 0xE9 it returns to 24 bits. The mode changes only when chip select rises at the end of those commands.
- R4: A write-lock command issued while write enable is not armed leaves every lock byte unchanged.
- R5: After write enable, a write-lock command stores its data byte in the addressed entry. A completed write disarms write enable, so a following write without a new 0x06 is ignored.
- R6: A read-lock command returns the addressed byte, high nibble first, in the two clocks after the address. Output data changes on the falling serial clock edge. dq_oe is high only during those two data clocks and is low during the address phase and while chip select is high.
- R7: A write is committed only if chip select rises right after the second data nibble. If chip select rises after one data nibble or after three, no entry changes, and write enable stays armed.
- R8: The entry index is the address field just above the sector offset (bits SECTOR_BITS upward). Offset bits and bits above the index do not select a different entry.
- R9: Chip select going high in the middle of a command abandons it. The next command is decoded from its first nibble.
- R10: After reset every lock byte is 0x00, dq_oe is low, write enable is disarmed and the address mode is 24 bits.
- R11: A write-enable command arms the target only if chip select rises right after its opcode. Extra clocks after the opcode cancel the arming.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, oversamples the serial lines |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, idle low |
| dq_in | input | 4 | Quad data lines as seen at the pads |
| dq_out | output | 4 | Quad data lines driven during read data |
| dq_oe | output | 4 | One-bit-per-line output enable, all bits equal |

## Verification
The bench builds the target with a 4096-byte sector offset and four lock entries. With that setting, a 24-bit address has many bits both below and above the two index bits. Aliasing through the offset and through the high address bits can therefore be checked with short addresses, and every entry can be written and read back. A 32-bit address in four-byte mode then places non-zero bits in the top byte, which must not disturb the index.

// File: rtl/qlk_pkg.sv
// Package: shared opcodes and phase type for the quad lock-register target.
// Assumes one nibble per serial clock in every phase.
package qlk_pkg;

    localparam int NIB_W      = 4;
    localparam int ADDR_MAX_W = 32;

    localparam logic [7:0] OP_WR_EN   = 8'h06;
    localparam logic [7:0] OP_LK_RD   = 8'hE8;
    localparam logic [7:0] OP_LK_WR   = 8'hE5;
    localparam logic [7:0] OP_ADDR4ON = 8'hB7;
    localparam logic [7:0] OP_ADDR4OF = 8'hE9;

    typedef enum logic [2:0] {
        PH_CMD,     // collecting opcode nibbles
        PH_ADDR,    // collecting address nibbles
        PH_RDATA,   // driving lock byte
        PH_WDATA,   // collecting lock byte
        PH_CMDEND,  // no-address command complete, waiting for cs rise
        PH_WDONE,   // write data complete, waiting for cs rise
        PH_IGNORE   // rest of transaction is ignored
    } qlk_phase_e;

endpackage

// File: rtl/qlk_sync.sv
// Module: synchronizes cs_n, sclk and dq_in into clk and flags sclk/cs edges.
// Assumes sclk half period is several clk cycles longer than STAGES+1.
module qlk_sync #(
    parameter int DQ_W   = 4,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n,
    input  logic            sclk,
    input  logic [DQ_W-1:0] dq_in,
    output logic            sclk_rise,
    output logic            sclk_fall,
    output logic            cs_hi,
    output logic            cs_rise,
    output logic [DQ_W-1:0] dq_s
);
    localparam int BUS_W = DQ_W + 2;
    localparam logic [BUS_W-1:0] RST_VAL = {1'b1, {(BUS_W-1){1'b0}}};

    logic [BUS_W-1:0] stg [STAGES];
    logic             sclk_d;
    logic             cs_d;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // capture raw pad levels
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= {cs_n, sclk, dq_in};
            end
        end else begin : g_next
            // pass along the synchronizer chain
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    // remember previous synchronized sclk and cs levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            cs_d   <= 1'b1;
        end else begin
            sclk_d <= stg[STAGES-1][DQ_W];
            cs_d   <= stg[STAGES-1][DQ_W+1];
        end
    end

    assign cs_hi     = stg[STAGES-1][DQ_W+1];
    assign cs_rise   = cs_hi & ~cs_d;
    assign sclk_rise = stg[STAGES-1][DQ_W] & ~sclk_d;
    assign sclk_fall = ~stg[STAGES-1][DQ_W] & sclk_d;
    assign dq_s      = stg[STAGES-1][DQ_W-1:0];

endmodule

// File: rtl/qlk_lock_array.sv
// Module: one lock byte per sector held in flops, single write port, one read port.
// Assumes ENTRIES is a power of two, so every index value selects an entry.
module qlk_lock_array #(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata
);
    logic [7:0] mem [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        // hold or update one lock byte
        always_ff @(posedge clk) begin
            if (!rst_n)                             mem[g] <= 8'h00;
            else if (we && (32'(idx) == g))         mem[g] <= wdata;
        end

        // an entry only moves on a write aimed at it
        p_entry_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && (32'(idx) == g)) |=> $stable(mem[g]));
    end

    assign rdata = mem[idx];

endmodule

// File: rtl/qlk_cmd_fsm.sv
// Module: nibble-serial command decoder for the lock path: opcode, address,
// read/write data, write-enable latch and address-length mode.
// Assumes edge strobes and data are already synchronized to clk.
module qlk_cmd_fsm
    import qlk_pkg::*;
#(
    parameter int SECTOR_BITS = 16,
    parameter int IDX_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_hi,
    input  logic             cs_rise,
    input  logic             sclk_rise,
    input  logic             sclk_fall,
    input  logic [NIB_W-1:0] nib,
    input  logic [7:0]       rd_byte,
    output logic [IDX_W-1:0] idx,
    output logic             lock_we,
    output logic [7:0]       lock_wdata,
    output logic [NIB_W-1:0] dq_out,
    output logic             dq_oe
);
    qlk_phase_e              phase_q;
    logic [3:0]              cnt_q;
    logic [7:0]              op_q;
    logic [ADDR_MAX_W-1:0]   addr_q;
    logic [7:0]              data_q;
    logic                    wel_q;
    logic                    four_q;
    logic                    oe_q;
    logic [NIB_W-1:0]        dout_q;
    logic [7:0]              op_next;
    logic [3:0]              addr_last;
    logic                    unused_addr;

    assign op_next   = {op_q[3:0], nib};
    assign addr_last = four_q ? 4'd7 : 4'd5;

    // main sequencer: phases, counters, latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_CMD;
            cnt_q   <= '0;
            op_q    <= '0;
            addr_q  <= '0;
            data_q  <= '0;
            wel_q   <= 1'b0;
            four_q  <= 1'b0;
            oe_q    <= 1'b0;
            dout_q  <= '0;
        end else if (cs_hi) begin
            phase_q <= PH_CMD;
            cnt_q   <= '0;
            oe_q    <= 1'b0;
            if (cs_rise) begin
                if (phase_q == PH_CMDEND) begin
                    case (op_q)
                        OP_WR_EN:   wel_q  <= 1'b1;
                        OP_ADDR4ON: four_q <= 1'b1;
                        OP_ADDR4OF: four_q <= 1'b0;
                        default:    ;
                    endcase
                end else if (phase_q == PH_WDONE && wel_q) begin
                    wel_q <= 1'b0;
                end
            end
        end else if (sclk_rise) begin
            case (phase_q)
                PH_CMD: begin
                    op_q <= op_next;
                    if (cnt_q == 4'd1) begin
                        cnt_q  <= '0;
                        addr_q <= '0;
                        case (op_next)
                            OP_WR_EN, OP_ADDR4ON, OP_ADDR4OF: phase_q <= PH_CMDEND;
                            OP_LK_RD, OP_LK_WR:               phase_q <= PH_ADDR;
                            default:                          phase_q <= PH_IGNORE;
                        endcase
                    end else begin
                        cnt_q <= cnt_q + 4'd1;
                    end
                end
                PH_ADDR: begin
                    addr_q <= {addr_q[ADDR_MAX_W-NIB_W-1:0], nib};
                    if (cnt_q == addr_last) begin
                        cnt_q   <= '0;
                        phase_q <= (op_q == OP_LK_RD) ? PH_RDATA : PH_WDATA;
                    end else begin
                        cnt_q <= cnt_q + 4'd1;
                    end
                end
                PH_RDATA: begin
                    if (cnt_q == 4'd1) begin
                        cnt_q   <= '0;
                        oe_q    <= 1'b0;
                        phase_q <= PH_IGNORE;
                    end else begin
                        cnt_q <= cnt_q + 4'd1;
                    end
                end
                PH_WDATA: begin
                    data_q <= {data_q[3:0], nib};
                    if (cnt_q == 4'd1) begin
                        cnt_q   <= '0;
                        phase_q <= PH_WDONE;
                    end else begin
                        cnt_q <= cnt_q + 4'd1;
                    end
                end
                PH_CMDEND, PH_WDONE: phase_q <= PH_IGNORE;
                default: ;
            endcase
        end else if (sclk_fall && phase_q == PH_RDATA) begin
            oe_q   <= 1'b1;
            dout_q <= (cnt_q == 4'd0) ? rd_byte[7:4] : rd_byte[3:0];
        end
    end

    assign idx         = addr_q[SECTOR_BITS +: IDX_W];
    assign unused_addr = ^addr_q;
    assign lock_we     = cs_rise && (phase_q == PH_WDONE) && wel_q;
    assign lock_wdata  = data_q;
    assign dq_out      = dout_q;
    assign dq_oe       = oe_q;

    // output enable only while the read data phase is active
    p_oe_in_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (phase_q == PH_RDATA));

    // a committed write disarms write enable
    p_commit_disarms_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lock_we |=> !wel_q);

    // address mode changes only at the end of a transaction
    p_mode_at_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_rise |=> $stable(four_q));

    // chip select high parks the decoder at the opcode phase
    p_cs_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_hi |=> (phase_q == PH_CMD && cnt_q == 4'd0));

endmodule

// File: rtl/qlk_lock_target.sv
// Module: top of the quad-I/O lock-register target. Oversamples the serial
// interface, decodes commands and keeps one lock byte per sector.
// Assumes sclk is idle low and much slower than clk.
module qlk_lock_target #(
    parameter int SECTOR_BITS  = 16,
    parameter int LOCK_ENTRIES = 16,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sclk,
    input  logic [3:0] dq_in,
    output logic [3:0] dq_out,
    output logic [3:0] dq_oe
);
    localparam int IDX_W = $clog2(LOCK_ENTRIES);

    logic             sclk_rise, sclk_fall, cs_hi, cs_rise;
    logic [3:0]       dq_s;
    logic [IDX_W-1:0] idx;
    logic             lock_we;
    logic [7:0]       lock_wdata, lock_rdata;
    logic             oe_bit;

    qlk_sync #(.DQ_W(4), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .dq_in(dq_in),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .cs_hi(cs_hi), .cs_rise(cs_rise), .dq_s(dq_s)
    );

    qlk_cmd_fsm #(.SECTOR_BITS(SECTOR_BITS), .IDX_W(IDX_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .cs_hi(cs_hi), .cs_rise(cs_rise),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .nib(dq_s),
        .rd_byte(lock_rdata), .idx(idx), .lock_we(lock_we),
        .lock_wdata(lock_wdata), .dq_out(dq_out), .dq_oe(oe_bit)
    );

    qlk_lock_array #(.ENTRIES(LOCK_ENTRIES), .IDX_W(IDX_W)) array_i (
        .clk(clk), .rst_n(rst_n), .we(lock_we), .idx(idx),
        .wdata(lock_wdata), .rdata(lock_rdata)
    );

    assign dq_oe = {4{oe_bit}};

    // nothing is driven once chip select is seen high
    p_idle_no_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_hi |=> (dq_oe == 4'h0));

    // a lock write only happens at the end of a transaction
    p_write_at_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lock_we |-> cs_hi);

endmodule

// File: tb/qlk_lock_target_tb.sv
// Bench: vector table of write/read pairs, then directed corner tests.
module qlk_lock_target_tb_top;
    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic [3:0] dq_in = 4'h0;
    logic [3:0] dq_out;
    logic [3:0] dq_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic oe_after_addr;
    logic oe_data;

    always #10 clk = ~clk;

    qlk_lock_target #(.SECTOR_BITS(12), .LOCK_ENTRIES(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    // {wren_first, write addr, write data, read addr, expected}
    localparam logic [64:0] VEC [6] = '{
        {1'b1, 24'h001000, 8'hA5, 24'h001000, 8'hA5},  // R5
        {1'b0, 24'h001000, 8'h3C, 24'h001FFF, 8'hA5},  // R4, R8 offset alias
        {1'b1, 24'h002345, 8'h5A, 24'h006000, 8'h5A},  // R8 high-bit alias
        {1'b1, 24'h003000, 8'hFF, 24'h003000, 8'hFF},  // R5
        {1'b1, 24'h000000, 8'h81, 24'hFF0000, 8'h81},  // R8
        {1'b0, 24'h003000, 8'h00, 24'h003ABC, 8'hFF}   // R4
    };

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic begin_xfer();
        @(negedge clk);
        sclk = 1'b0;
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic end_xfer();
        @(negedge clk);
        sclk = 1'b0;
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(3 * HALF);
    endtask

    task automatic nib_out(input logic [3:0] n);
        sclk  = 1'b0;
        dq_in = n;
        wait_clk(HALF);
        sclk = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic nib_in(output logic [3:0] n, output logic oe);
        sclk = 1'b0;
        wait_clk(HALF);
        n  = dq_out;
        oe = dq_oe[0];
        sclk = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic byte_out(input logic [7:0] b);
        nib_out(b[7:4]);
        nib_out(b[3:0]);
    endtask

    task automatic addr_out(input logic [31:0] a, input int nibs);
        for (int i = nibs - 1; i >= 0; i--) nib_out(a[i*4 +: 4]);
    endtask

    task automatic cmd_only(input logic [7:0] op);
        begin_xfer();
        byte_out(op);
        end_xfer();
    endtask

    task automatic lock_write(input logic [31:0] a, input logic [7:0] d, input int nibs);
        begin_xfer();
        byte_out(8'hE5);
        addr_out(a, nibs);
        byte_out(d);
        end_xfer();
    endtask

    task automatic lock_read(input logic [31:0] a, input int nibs, output logic [7:0] d);
        logic [3:0] hi, lo;
        logic oe1, oe2;
        begin_xfer();
        byte_out(8'hE8);
        addr_out(a, nibs);
        oe_after_addr = dq_oe[0];
        nib_in(hi, oe1);
        nib_in(lo, oe2);
        oe_data = oe1 & oe2;
        end_xfer();
        d = {hi, lo};
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        // R10: reset state
        check(dq_oe == 4'h0, "R10 oe after reset", dq_oe, 0);
        for (int e = 0; e < 4; e++) begin
            lock_read(32'(e) << 12, 6, rd);
            check(rd == 8'h00, "R10 entry zero after reset", rd, 0);
        end
        // R4: write without write enable is ignored
        lock_write(32'h001000, 8'h77, 6);
        lock_read(32'h001000, 6, rd);
        check(rd == 8'h00, "R4 write without enable", rd, 0);

        // vector table (R1, R2, R4, R5, R8)
        for (int v = 0; v < 6; v++) begin
            if (VEC[v][64]) cmd_only(8'h06);
            lock_write({8'h00, VEC[v][63:40]}, VEC[v][39:32], 6);
            lock_read({8'h00, VEC[v][31:8]}, 6, rd);
            check(rd == VEC[v][7:0], "R1/R5/R8 vector readback", rd, VEC[v][7:0]);
        end

        // R5: second write without new enable ignored
        cmd_only(8'h06);
        lock_write(32'h001000, 8'h42, 6);
        lock_write(32'h001000, 8'h24, 6);
        lock_read(32'h001000, 6, rd);
        check(rd == 8'h42, "R5 enable consumed by write", rd, 8'h42);

        // R7: early and late chip select abort the write, enable stays armed
        cmd_only(8'h06);
        begin_xfer(); byte_out(8'hE5); addr_out(32'h001000, 6); nib_out(4'h1); end_xfer();
        lock_read(32'h001000, 6, rd);
        check(rd == 8'h42, "R7 early cs abort", rd, 8'h42);
        begin_xfer(); byte_out(8'hE5); addr_out(32'h001000, 6); byte_out(8'h22); nib_out(4'h3); end_xfer();
        lock_read(32'h001000, 6, rd);
        check(rd == 8'h42, "R7 late cs abort", rd, 8'h42);
        lock_write(32'h001000, 8'h33, 6);
        lock_read(32'h001000, 6, rd);
        check(rd == 8'h33, "R7 enable kept after abort", rd, 8'h33);

        // R11: write enable with trailing clocks does not arm
        begin_xfer(); byte_out(8'h06); nib_out(4'h0); end_xfer();
        lock_write(32'h002000, 8'h99, 6);
        lock_read(32'h002000, 6, rd);
        check(rd == 8'h5A, "R11 wren not on byte boundary", rd, 8'h5A);

        // R9: chip select mid-address, then a clean read
        begin_xfer(); byte_out(8'hE8); nib_out(4'h0); nib_out(4'h0); end_xfer();
        lock_read(32'h003000, 6, rd);
        check(rd == 8'hFF, "R9 restart after abort", rd, 8'hFF);

        // R3: four-byte address mode
        cmd_only(8'hB7);
        cmd_only(8'h06);
        lock_write(32'hAB002000, 8'h77, 8);
        lock_read(32'h00002FFF, 8, rd);
        check(rd == 8'h77, "R3 32-bit address write/read", rd, 8'h77);
        cmd_only(8'hE9);
        lock_read(32'h002000, 6, rd);
        check(rd == 8'h77, "R2/R3 back to 24-bit address", rd, 8'h77);

        // R6: nibble order and output enable window
        lock_read(32'h000000, 6, rd);
        check(rd == 8'h81, "R6 high nibble first", rd, 8'h81);
        check(oe_after_addr == 1'b0, "R6 oe low in address phase", oe_after_addr, 0);
        check(oe_data == 1'b1, "R6 oe high in data phase", oe_data, 1);
        check(dq_oe == 4'h0, "R6 oe low with cs high", dq_oe, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule